// File: doc/BRIEF.md
# Channel-Parallel Multiply-Accumulate Array

This block is the arithmetic heart of one convolution step in a line-by-line (layer-fused) neural network engine. Each accepted beat carries the N input-channel values of one pixel and an N×N weight tile. Every input channel is multiplied by N weights, one per output channel, and a pipelined adder tree per output channel reduces the N products to one sum. A row of N accumulator adders then adds one addend per lane: a bias on the first pass over an output, a stored partial sum on later passes, the matching feature of the other stereo path when an element-wise addition is fused into the final pass, or nothing.

Two results leave the block per beat. The wide partial sum is returned at full accumulator width so the caller can store and feed it back on the next pass. The narrow feature is the same sum passed through an optional rectifier and clamped to the signed word range, ready to be written as a finished activation. Operand storage and loop scheduling sit outside the block; every operand and select arrives with the beat.

Both data sides are valid/ready streams. A beat is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is taken on an edge where `out_valid` and `out_ready` are both high. While a result waits (`out_valid` high, `out_ready` low) the whole pipeline freezes, the result holds steady and `in_ready` is low. The mode and rectifier pins travel with the beat and are sampled only when it is taken.

Top module: `cpm_mac_array`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `out_ready` held high, a beat taken on edge E0 produces its result with `out_valid` high right after edge E0+log2(N)+1, and `out_valid` is still 0 right after edge E0+log2(N).
- R3: With `in_mode` = 0, lane k of `out_psum` equals the sum over i of feat[i]·wgt[i][k] plus the sign-extended `in_bias` lane k. All words are signed two's complement. Feature i sits at `in_feat` bits [i·R +: R], weight (i,k) at `in_wgt` bits [(i·N+k)·R +: R], and lane k of every N-lane bus at bits [k·W +: W], where W is that bus's word width.
- R4: With `in_mode` = 1, the addend is lane k of `in_psum`, a full ACC_W-bit word, where ACC_W = 2R+log2(N). The sum wraps modulo 2^ACC_W.
- R5: With `in_mode` = 2, the addend is the sign-extended lane k of `in_left`, which is the other stereo path's feature.
- R6: With `in_mode` = 3, nothing is added to the dot product.
- R7: With `in_relu` = 1, a lane whose accumulated sum is negative gives `out_feat` 0.
- R8: Otherwise `out_feat` is the accumulated sum clamped to [-2^(R-1), 2^(R-1)-1]. A positive sum is clamped this way whatever `in_relu` is.
- R9: While `out_valid` is 1 and `out_ready` is 0, on the next cycle `out_valid` is still 1 and `out_psum` and `out_feat` are unchanged.
- R10: `in_ready` is 0 exactly when a result waits unaccepted. Results leave in the order their beats were taken, none lost or duplicated, and at most log2(N)+2 beats are inside the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_feat | input | N·R | Input-channel features of one pixel |
| in_wgt | input | N·N·R | Weight tile, entry (i,k) at word i·N+k |
| in_mode | input | 2 | Addend select: 0 bias, 1 partial sum, 2 left feature, 3 none |
| in_bias | input | N·R | Per-output-channel bias |
| in_psum | input | N·ACC_W | Stored partial sums |
| in_left | input | N·R | Other stereo path's features |
| in_relu | input | 1 | Apply rectifier to the narrow result |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_psum | output | N·ACC_W | Accumulated sums, full width |
| out_feat | output | N·R | Rectified, clamped features |

## Verification
The functions that most often meet in one cycle are the back-pressure freeze and the taking of a new beat. When a result waits while the source still offers data, the block must refuse the offered beat and keep the waiting result steady, and it must take the beat again once the result leaves. The bench streams beats with no gaps while `out_ready` goes high and low at random. It compares each result, in order, against a reference dot product and checks that a waiting result does not change and that `in_ready` stays low while a result waits. A second case sets the rectifier and the clamp on the same lane at once: a large negative sum must give 0 with the rectifier enabled and the minimum word without it.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  typedef enum logic [1:0] {
    ADD_BIAS = 2'd0,
    ADD_PSUM = 2'd1,
    ADD_LEFT = 2'd2,
    ADD_NONE = 2'd3
  } addend_sel_e;
endpackage

// File: rtl/cpm_mult_grid.sv
// N x N multiplier grid: row i carries input channel i, column k output channel k.
// Products are registered and sign-extended to accumulator width, grouped by column.
module cpm_mult_grid #(
  parameter int N     = 4,
  parameter int R     = 8,
  parameter int ACC_W = 2 * R + $clog2(N)
) (
  input  logic                   clk,
  input  logic                   adv,
  input  logic [N*R-1:0]         feat,
  input  logic [N*N*R-1:0]       wgt,
  output logic [N*N*ACC_W-1:0]   col_prod
);
  localparam int PW = 2 * R;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar k = 0; k < N; k++) begin : g_col
      logic signed [PW-1:0]    prod;
      logic signed [ACC_W-1:0] prod_q;
      assign prod = $signed(feat[i*R +: R]) * $signed(wgt[(i*N+k)*R +: R]);
      always_ff @(posedge clk) begin
        if (adv) prod_q <= ACC_W'(prod);
      end
      assign col_prod[(k*N+i)*ACC_W +: ACC_W] = prod_q;
    end
  end
endmodule

// File: rtl/cpm_col_tree.sv
// Pipelined binary adder tree of one column: log2(N) registered levels.
module cpm_col_tree #(
  parameter int N     = 4,
  parameter int ACC_W = 18
) (
  input  logic                 clk,
  input  logic                 adv,
  input  logic [N*ACC_W-1:0]   leaves,
  output logic [ACC_W-1:0]     sum
);
  localparam int LVL = $clog2(N);

  for (genvar l = 0; l <= LVL; l++) begin : g_lvl
    localparam int NODES = N >> l;
    logic [NODES*ACC_W-1:0] node;
    if (l == 0) begin : g_leaf
      assign node = leaves;
    end else begin : g_add
      always_ff @(posedge clk) begin
        if (adv) begin
          for (int j = 0; j < NODES; j++) begin
            node[j*ACC_W +: ACC_W] <= g_lvl[l-1].node[(2*j)*ACC_W +: ACC_W]
                                    + g_lvl[l-1].node[(2*j+1)*ACC_W +: ACC_W];
          end
        end
      end
    end
  end

  assign sum = g_lvl[LVL].node;
endmodule

// File: rtl/cpm_delay.sv
// Enabled shift chain with reset, used to carry sideband and valid alongside the tree.
module cpm_delay #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [D];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < D; i++) st[i] <= '0;
    end else if (adv) begin
      st[0] <= d;
      for (int i = 1; i < D; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[D-1];
endmodule

// File: rtl/cpm_acc_relu.sv
// Accumulator adder row with a four-way addend select, then rectify and clamp.
module cpm_acc_relu
  import cpm_pkg::*;
#(
  parameter int N     = 4,
  parameter int R     = 8,
  parameter int ACC_W = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 in_vld,
  input  logic [N*ACC_W-1:0]   sums,
  input  logic [1:0]           sel,
  input  logic [N*R-1:0]       bias,
  input  logic [N*ACC_W-1:0]   psum,
  input  logic [N*R-1:0]       left,
  input  logic                 relu,
  output logic                 out_vld,
  output logic [N*ACC_W-1:0]   out_psum,
  output logic [N*R-1:0]       out_feat
);
  logic relu_q;
  addend_sel_e sel_e;
  assign sel_e = addend_sel_e'(sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      relu_q  <= 1'b0;
    end else if (adv) begin
      out_vld <= in_vld;
      relu_q  <= relu;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_lane
    logic signed [ACC_W-1:0] addend;
    logic signed [ACC_W-1:0] acc_q;
    logic [ACC_W-R:0]        top_bits;
    logic                    ovf;

    always_comb begin
      unique case (sel_e)
        ADD_BIAS: addend = ACC_W'($signed(bias[k*R +: R]));
        ADD_PSUM: addend = $signed(psum[k*ACC_W +: ACC_W]);
        ADD_LEFT: addend = ACC_W'($signed(left[k*R +: R]));
        default:  addend = '0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (adv) acc_q <= $signed(sums[k*ACC_W +: ACC_W]) + addend;
    end

    assign top_bits = acc_q[ACC_W-1:R-1];
    assign ovf      = !((&top_bits) || !(|top_bits));

    always_comb begin
      if (relu_q && acc_q[ACC_W-1])
        out_feat[k*R +: R] = '0;
      else if (ovf && !acc_q[ACC_W-1])
        out_feat[k*R +: R] = {1'b0, {(R-1){1'b1}}};
      else if (ovf)
        out_feat[k*R +: R] = {1'b1, {(R-1){1'b0}}};
      else
        out_feat[k*R +: R] = acc_q[R-1:0];
    end

    assign out_psum[k*ACC_W +: ACC_W] = acc_q;
  end
endmodule

// File: rtl/cpm_mac_array.sv
// Channel-parallel MAC array: multiplier grid, column trees, accumulator row, rectify/clamp.
module cpm_mac_array #(
  parameter int N = 4,
  parameter int R = 8,
  localparam int LVL   = $clog2(N),
  localparam int ACC_W = 2 * R + LVL,
  localparam int LAT   = LVL + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [N*R-1:0]       in_feat,
  input  logic [N*N*R-1:0]     in_wgt,
  input  logic [1:0]           in_mode,
  input  logic [N*R-1:0]       in_bias,
  input  logic [N*ACC_W-1:0]   in_psum,
  input  logic [N*R-1:0]       in_left,
  input  logic                 in_relu,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [N*ACC_W-1:0]   out_psum,
  output logic [N*R-1:0]       out_feat
);
  localparam int SB_W = 1 + 2 + N*R + N*ACC_W + N*R + 1;

  logic                 adv;
  logic [N*N*ACC_W-1:0] col_prod;
  logic [N*ACC_W-1:0]   col_sum;
  logic [SB_W-1:0]      sb_in, sb_out;
  logic                 d_vld, d_relu;
  logic [1:0]           d_mode;
  logic [N*R-1:0]       d_bias, d_left;
  logic [N*ACC_W-1:0]   d_psum;

  // whole pipeline moves unless a finished result is waiting
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  cpm_mult_grid #(.N(N), .R(R), .ACC_W(ACC_W)) u_grid (
    .clk      (clk),
    .adv      (adv),
    .feat     (in_feat),
    .wgt      (in_wgt),
    .col_prod (col_prod)
  );

  for (genvar k = 0; k < N; k++) begin : g_tree
    cpm_col_tree #(.N(N), .ACC_W(ACC_W)) u_tree (
      .clk    (clk),
      .adv    (adv),
      .leaves (col_prod[k*N*ACC_W +: N*ACC_W]),
      .sum    (col_sum[k*ACC_W +: ACC_W])
    );
  end

  assign sb_in = {in_valid && in_ready, in_mode, in_bias, in_psum, in_left, in_relu};

  cpm_delay #(.W(SB_W), .D(LVL + 1)) u_side (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .d     (sb_in),
    .q     (sb_out)
  );

  assign {d_vld, d_mode, d_bias, d_psum, d_left, d_relu} = sb_out;

  cpm_acc_relu #(.N(N), .R(R), .ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .in_vld   (d_vld),
    .sums     (col_sum),
    .sel      (d_mode),
    .bias     (d_bias),
    .psum     (d_psum),
    .left     (d_left),
    .relu     (d_relu),
    .out_vld  (out_valid),
    .out_psum (out_psum),
    .out_feat (out_feat)
  );
endmodule

// File: rtl/cpm_mac_array_chk.sv
module cpm_mac_array_chk #(
  parameter int N     = 4,
  parameter int R     = 8,
  parameter int ACC_W = 18,
  parameter int LAT   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [N*ACC_W-1:0] out_psum,
  input logic [N*R-1:0]     out_feat
);
  localparam int CW = $clog2(LAT + 2) + 1;
  logic [CW-1:0] inflight;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + CW'(in_valid && in_ready) - CW'(out_valid && out_ready);
  end

  a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_psum) && $stable(out_feat)));
  a_r10_no_take_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  a_r10_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(LAT));
  a_r10_out_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (inflight != '0));

  for (genvar k = 0; k < N; k++) begin : g_lane
    logic [ACC_W-1:0] s;
    logic [R-1:0]     f;
    assign s = out_psum[k*ACC_W +: ACC_W];
    assign f = out_feat[k*R +: R];
    a_r8_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !s[ACC_W-1] && (|s[ACC_W-2:R-1])) |-> (f == {1'b0, {(R-1){1'b1}}}));
    a_r7_negative_out: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && s[ACC_W-1]) |-> ((f == '0) || f[R-1]));
  end
endmodule

bind cpm_mac_array cpm_mac_array_chk #(.N(N), .R(R), .ACC_W(ACC_W), .LAT(LAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_psum  (out_psum),
  .out_feat  (out_feat)
);

// File: tb/cpm_mac_array_tb.sv
module cpm_mac_array_tb;
  localparam int N          = 4;
  localparam int R          = 8;
  localparam int LVL        = $clog2(N);
  localparam int ACC_W      = 2 * R + LVL;
  localparam int CLK_PERIOD = 10;
  localparam int NT         = 8;
  localparam int K          = 16;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic [N*R-1:0]       in_feat = '0;
  logic [N*N*R-1:0]     in_wgt = '0;
  logic [1:0]           in_mode = '0;
  logic [N*R-1:0]       in_bias = '0;
  logic [N*ACC_W-1:0]   in_psum = '0;
  logic [N*R-1:0]       in_left = '0;
  logic                 in_relu = 1'b0;
  logic                 out_valid;
  logic                 out_ready = 1'b1;
  logic [N*ACC_W-1:0]   out_psum;
  logic [N*R-1:0]       out_feat;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpm_mac_array #(.N(N), .R(R)) u_dut (.*);

  typedef struct packed {
    logic [N*R-1:0]     f;
    logic [N*N*R-1:0]   w;
    logic [1:0]         m;
    logic [N*R-1:0]     b;
    logic [N*ACC_W-1:0] p;
    logic [N*R-1:0]     l;
    logic               relu;
  } vec_t;

  localparam vec_t TABLE [NT] = '{
    // R3 small dot products with bias
    '{f: 32'h04030201, w: {16{8'h01}}, m: 2'd0, b: 32'h05fb0a00, p: '0, l: '0, relu: 1'b0},
    // R4 partial sums, rectifier on
    '{f: 32'hfe0302ff, w: 128'h01ff02fe_03fd04fc_7f80017f_10f0e020, m: 2'd1, b: '0,
      p: {18'h3ff00, 18'h00100, 18'h3fffe, 18'h00020}, l: '0, relu: 1'b1},
    // R5 fused left-path addition
    '{f: 32'h10f00810, w: 128'h0102030405060708090a0b0c0d0e0f10, m: 2'd2, b: 32'hffffffff,
      p: '0, l: 32'h80ff7f01, relu: 1'b0},
    // R6 no addend
    '{f: 32'h11223344, w: 128'hfedcba9876543210_0123456789abcdef, m: 2'd3, b: 32'h7f7f7f7f,
      p: {4{18'h1ffff}}, l: 32'h7f7f7f7f, relu: 1'b0},
    // R8 positive clamp, rectifier on
    '{f: {4{8'h7f}}, w: {16{8'h7f}}, m: 2'd0, b: '0, p: '0, l: '0, relu: 1'b1},
    // R8 negative clamp, rectifier off
    '{f: {4{8'h80}}, w: {16{8'h7f}}, m: 2'd0, b: '0, p: '0, l: '0, relu: 1'b0},
    // R7 same large negative sum, rectifier on
    '{f: {4{8'h80}}, w: {16{8'h7f}}, m: 2'd0, b: '0, p: '0, l: '0, relu: 1'b1},
    // R4 wrap at accumulator width
    '{f: {4{8'h80}}, w: {16{8'h80}}, m: 2'd1, b: '0, p: {4{18'h1ffff}}, l: '0, relu: 1'b0}
  };

  function automatic logic [N*ACC_W-1:0] ref_psum(input vec_t v);
    logic [N*ACC_W-1:0] res;
    for (int k = 0; k < N; k++) begin
      longint s = 0;
      for (int i = 0; i < N; i++)
        s = s + $signed(v.f[i*R +: R]) * $signed(v.w[(i*N+k)*R +: R]);
      case (v.m)
        2'd0: s = s + $signed(v.b[k*R +: R]);
        2'd1: s = s + $signed(v.p[k*ACC_W +: ACC_W]);
        2'd2: s = s + $signed(v.l[k*R +: R]);
        default: ;
      endcase
      res[k*ACC_W +: ACC_W] = s[ACC_W-1:0];
    end
    return res;
  endfunction

  function automatic logic [N*R-1:0] ref_feat(input logic [N*ACC_W-1:0] ps, input logic relu);
    logic [N*R-1:0] res;
    for (int k = 0; k < N; k++) begin
      longint v = $signed(ps[k*ACC_W +: ACC_W]);
      if (relu && v < 0) v = 0;
      if (v > (2**(R-1)) - 1) v = (2**(R-1)) - 1;
      if (v < -(2**(R-1))) v = -(2**(R-1));
      res[k*R +: R] = v[R-1:0];
    end
    return res;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_feat = v.f; in_wgt = v.w; in_mode = v.m; in_bias = v.b;
    in_psum = v.p; in_left = v.l; in_relu = v.relu;
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  vec_t sv [K];
  logic [N*ACC_W-1:0] ep [K];
  logic [N*R-1:0]     ef [K];

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", 128'(out_valid), 128'(0));
    check(in_ready == 1'b1, "R1 in_ready after reset", 128'(in_ready), 128'(1));

    // table walk, one beat at a time with out_ready high
    for (int t = 0; t < NT; t++) begin
      logic [N*ACC_W-1:0] xp;
      logic [N*R-1:0]     xf;
      xp = ref_psum(TABLE[t]);
      xf = ref_feat(xp, TABLE[t].relu);
      @(negedge clk);
      drive(TABLE[t]);
      in_valid = 1'b1;
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (LVL) @(negedge clk);
      check(out_valid == 1'b0, "R2 result not yet present", 128'(out_valid), 128'(0));
      @(negedge clk);
      check(out_valid == 1'b1, "R2 result present at latency", 128'(out_valid), 128'(1));
      check(out_psum == xp, mode_tag(TABLE[t].m), 128'(out_psum), 128'(xp));
      check(out_feat == xf, TABLE[t].relu ? "R7 rectified feature" : "R8 clamped feature",
            128'(out_feat), 128'(xf));
    end

    // streaming with random back-pressure
    for (int j = 0; j < K; j++) begin
      sv[j].f = $urandom; sv[j].w = {$urandom, $urandom, $urandom, $urandom};
      sv[j].m = 2'($urandom); sv[j].b = $urandom;
      sv[j].p = {$urandom, $urandom, $urandom}; sv[j].l = $urandom;
      sv[j].relu = 1'($urandom);
      ep[j] = ref_psum(sv[j]);
      ef[j] = ref_feat(ep[j], sv[j].relu);
    end
    begin
      int tx = 0;
      int rx = 0;
      int guard = 0;
      bit held = 0;
      logic [N*ACC_W-1:0] hp;
      logic [N*R-1:0]     hf;
      while (rx < K && guard < 2000) begin
        @(negedge clk);
        guard++;
        out_ready = ($urandom % 3) != 0;
        if (tx < K) begin
          drive(sv[tx]);
          in_valid = 1'b1;
        end else begin
          in_valid = 1'b0;
        end
        #1;
        if (held) begin
          check(out_valid && out_psum == hp && out_feat == hf, "R9 waiting result held",
                128'(out_psum), 128'(hp));
        end
        if (out_valid && !out_ready) begin
          check(in_ready == 1'b0, "R10 in_ready low while result waits", 128'(in_ready), 128'(0));
          held = 1; hp = out_psum; hf = out_feat;
        end else begin
          held = 0;
        end
        if (out_valid && out_ready) begin
          check(out_psum == ep[rx], "R10 in-order partial sum", 128'(out_psum), 128'(ep[rx]));
          check(out_feat == ef[rx], "R10 in-order feature", 128'(out_feat), 128'(ef[rx]));
          rx++;
        end
        if (in_valid && in_ready) tx++;
      end
      check(rx == K, "R10 all results delivered", 128'(rx), 128'(K));
      @(negedge clk);
      in_valid = 1'b0;
      out_ready = 1'b1;
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule